// File: doc/BRIEF.md
# Oscillator Frequency Ratio Meter

This block turns two free-running delay-loop oscillators into one response word that does not depend on supply or temperature. Such effects stretch every delay in the chip by about the same factor, so the block reports the ratio of the two loop frequencies rather than either frequency alone. One start pulse launches a complete measurement. The block enables loop A, counts its rising edges against the reference clock for a programmed number of cycles, and then turns loop A off. It then does the same for loop B. Last, it divides the first count by the second in fixed point.

The two loops never run at the same time. Loops at nearly equal frequencies pull each other into lock, and the ratio then collapses to exactly one. The loop inputs are asynchronous to the reference clock. Each loop passes through a synchronizer before edge detection. Each count saturates instead of wrapping. A window of tens of thousands of loop periods gives a precision of a few hundred parts per million. The result stays on the output, with a valid flag, until the next measurement is accepted.

Top module: `freq_ratio_meter`

## Requirements
- R1: After reset both loop enables, `busy_o`, `valid_o`, `div_err_o` and `ratio_o` are all zero.
- R2: An accepted start enables loop A alone for exactly max(W,1) reference cycles. Loop B alone is then enabled for max(W,1) cycles, starting in the very next cycle. W is the `window_i` value captured with the start.
- R3: `loop_en_a_o` and `loop_en_b_o` are never high in the same cycle.
- R4: Each count is the number of rising edges of its synchronized loop input that are seen while that loop's own enable is high.
- R5: `ratio_o` is floor(countA * 2^FRAC_W / countB) as an unsigned value of CNT_W+FRAC_W bits. Its low FRAC_W bits are the fraction.
- R6: When countB is zero, `ratio_o` is all ones and `div_err_o` is 1. In every other case `div_err_o` is 0.
- R7: A start that arrives while a measurement is in progress (`busy_o` high) is ignored. The enable timing, the latency and the result are the same as in an undisturbed run. While `valid_o` is high, `ratio_o` and `div_err_o` stay constant, and `busy_o` and both enables stay low.
- R8: A start given while a result is valid is accepted. In the next cycle `valid_o` is low and loop A is enabled.
- R9: A window value of 0 is treated as a window of one cycle.
- R10: A loop count stops at 2^CNT_W-1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that starts a measurement |
| window_i | input | WIN_W | Window length in reference cycles, captured when a start is accepted |
| loop_a_i | input | 1 | Oscillating output of delay loop A (asynchronous) |
| loop_b_i | input | 1 | Oscillating output of delay loop B (asynchronous) |
| loop_en_a_o | output | 1 | Lets loop A oscillate |
| loop_en_b_o | output | 1 | Lets loop B oscillate |
| busy_o | output | 1 | A measurement or division is in progress |
| valid_o | output | 1 | `ratio_o` holds a finished result |
| ratio_o | output | CNT_W+FRAC_W | Fixed-point countA/countB |
| div_err_o | output | 1 | The last result came from a zero loop-B count |

## Verification
The bound checker watches four things on every cycle:
- the two loop enables are mutually exclusive;
- loop B is enabled directly after loop A;
- a zero-divisor result is all ones;
- a valid result holds steady until a restart, and a restart clears it.

Only the directed scenarios can show the arithmetic and the timing: exact ratios for chosen loop periods, enable windows of exactly W cycles, saturation of a count, and the degenerate zero window. They also show that a start injected mid-run leaves the latency and the result unchanged.

// File: rtl/frm_pkg.sv
package frm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN_A,
        ST_RUN_B,
        ST_DIVIDE,
        ST_DONE
    } meter_state_e;

endpackage

// File: rtl/loop_edge_sync.sv
module loop_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic loop_i,
    output logic rise_o
);
    // Chain: STAGES synchronizer flops plus one history flop for the edge detector.
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], loop_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/sat_edge_counter.sv
module sat_edge_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                         cnt_d = '0;
        else if (inc_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/ratio_divider.sv
module ratio_divider #(
    parameter int NUM_W = 40,
    parameter int DEN_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quot_o,
    output logic             zero_o
);
    localparam int ITER_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic              busy;
        logic [ITER_W-1:0] iter;
        logic [DEN_W:0]    rem;
        logic [NUM_W-1:0]  quo;   // dividend bits shift out at the top, quotient bits shift in at the bottom
        logic [DEN_W-1:0]  den;
        logic              done;
        logic              zero;
    } div_regs_t;

    div_regs_t q, d;
    logic [DEN_W:0] trial;
    logic           qbit;

    always_comb begin
        d     = q;
        d.done = 1'b0;
        trial = {q.rem[DEN_W-1:0], q.quo[NUM_W-1]};
        qbit  = 1'b0;
        if (start_i) begin
            d.iter = '0;
            d.rem  = '0;
            d.den  = den_i;
            if (den_i == '0) begin
                d.busy = 1'b0;
                d.quo  = '1;
                d.zero = 1'b1;
                d.done = 1'b1;
            end else begin
                d.busy = 1'b1;
                d.quo  = num_i;
                d.zero = 1'b0;
            end
        end else if (q.busy) begin
            if (trial >= {1'b0, q.den}) begin
                d.rem = trial - {1'b0, q.den};
                qbit  = 1'b1;
            end else begin
                d.rem = trial;
            end
            d.quo = {q.quo[NUM_W-2:0], qbit};
            if (q.iter == ITER_W'(NUM_W - 1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.iter = q.iter + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign done_o = q.done;
    assign quot_o = q.quo;
    assign zero_o = q.zero;

endmodule

// File: rtl/freq_ratio_meter.sv
module freq_ratio_meter #(
    parameter int CNT_W       = 24,
    parameter int FRAC_W      = 16,
    parameter int WIN_W       = 24,
    parameter int SYNC_STAGES = 2,
    localparam int RATIO_W    = CNT_W + FRAC_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic [WIN_W-1:0]   window_i,
    input  logic               loop_a_i,
    input  logic               loop_b_i,
    output logic               loop_en_a_o,
    output logic               loop_en_b_o,
    output logic               busy_o,
    output logic               valid_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               div_err_o
);
    import frm_pkg::*;

    localparam int NUM_LOOPS = 2;

    typedef struct packed {
        meter_state_e       state;
        logic [WIN_W-1:0]   win;
        logic [WIN_W-1:0]   timer;
        logic               div_go;
        logic [RATIO_W-1:0] ratio;
        logic               err;
        logic               valid;
    } meter_regs_t;

    meter_regs_t q, d;

    logic [NUM_LOOPS-1:0] loop_raw, loop_rise, loop_inc;
    logic [CNT_W-1:0]     loop_cnt [NUM_LOOPS];
    logic                 cnt_clr;
    logic                 start_ok;
    logic                 div_done, div_zero;
    logic [RATIO_W-1:0]   div_quot;

    assign loop_raw = {loop_b_i, loop_a_i};
    assign loop_inc = {loop_rise[1] & (q.state == ST_RUN_B),
                       loop_rise[0] & (q.state == ST_RUN_A)};

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
        loop_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .loop_i (loop_raw[g]),
            .rise_o (loop_rise[g])
        );
        sat_edge_counter #(.CNT_W(CNT_W)) i_cnt (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clr_i   (cnt_clr),
            .inc_i   (loop_inc[g]),
            .count_o (loop_cnt[g])
        );
    end

    ratio_divider #(.NUM_W(RATIO_W), .DEN_W(CNT_W)) i_div (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (q.div_go),
        .num_i   ({loop_cnt[0], {FRAC_W{1'b0}}}),
        .den_i   (loop_cnt[1]),
        .done_o  (div_done),
        .quot_o  (div_quot),
        .zero_o  (div_zero)
    );

    // Timer preset: a window of W cycles counts down W-1..0; zero behaves as one.
    function automatic logic [WIN_W-1:0] preset(input logic [WIN_W-1:0] w);
        return (w == '0) ? '0 : w - 1'b1;
    endfunction

    assign start_ok = start_i && (q.state == ST_IDLE || q.state == ST_DONE);

    always_comb begin
        d        = q;
        d.div_go = 1'b0;
        cnt_clr  = 1'b0;
        unique case (q.state)
            ST_IDLE, ST_DONE: begin
                if (start_ok) begin
                    d.state = ST_RUN_A;
                    d.win   = window_i;
                    d.timer = preset(window_i);
                    d.valid = 1'b0;
                    cnt_clr = 1'b1;
                end
            end
            ST_RUN_A: begin
                if (q.timer == '0) begin
                    d.state = ST_RUN_B;
                    d.timer = preset(q.win);
                end else begin
                    d.timer = q.timer - 1'b1;
                end
            end
            ST_RUN_B: begin
                if (q.timer == '0) begin
                    d.state  = ST_DIVIDE;
                    d.div_go = 1'b1;
                end else begin
                    d.timer = q.timer - 1'b1;
                end
            end
            ST_DIVIDE: begin
                if (div_done) begin
                    d.state = ST_DONE;
                    d.ratio = div_quot;
                    d.err   = div_zero;
                    d.valid = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign loop_en_a_o = (q.state == ST_RUN_A);
    assign loop_en_b_o = (q.state == ST_RUN_B);
    assign busy_o      = (q.state == ST_RUN_A) || (q.state == ST_RUN_B) || (q.state == ST_DIVIDE);
    assign valid_o     = q.valid;
    assign ratio_o     = q.ratio;
    assign div_err_o   = q.err;

endmodule

// File: rtl/frm_checker.sv
module frm_checker #(
    parameter int RATIO_W = 40
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               start_i,
    input logic               loop_en_a_o,
    input logic               loop_en_b_o,
    input logic               busy_o,
    input logic               valid_o,
    input logic [RATIO_W-1:0] ratio_o,
    input logic               div_err_o
);
    AST_EN_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(loop_en_a_o && loop_en_b_o)); // R3

    AST_A_HANDS_TO_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(loop_en_a_o) |-> loop_en_b_o); // R2

    AST_B_FOLLOWS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(loop_en_b_o) |-> $past(loop_en_a_o)); // R2

    AST_ZERO_DIV_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && div_err_o) |-> (ratio_o == {RATIO_W{1'b1}})); // R6

    AST_RESULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && !start_i) |=> (valid_o && $stable(ratio_o) && $stable(div_err_o))); // R7

    AST_VALID_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (!busy_o && !loop_en_a_o && !loop_en_b_o)); // R7

    AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && start_i) |=> (!valid_o && loop_en_a_o)); // R8

endmodule

bind freq_ratio_meter frm_checker #(.RATIO_W(RATIO_W)) i_frm_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .loop_en_a_o (loop_en_a_o),
    .loop_en_b_o (loop_en_b_o),
    .busy_o      (busy_o),
    .valid_o     (valid_o),
    .ratio_o     (ratio_o),
    .div_err_o   (div_err_o)
);

// File: tb/test_freq_ratio_meter.sv
`timescale 1ns/1ps
module test_freq_ratio_meter;
    localparam int CNT_W   = 10;
    localparam int FRAC_W  = 16;
    localparam int WIN_W   = 16;
    localparam int RATIO_W = CNT_W + FRAC_W;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [WIN_W-1:0]   window = '0;
    logic               loop_a = 1'b0;
    logic               loop_b = 1'b0;
    logic               en_a, en_b, busy, valid, err;
    logic [RATIO_W-1:0] ratio;

    int n_checks = 0;
    int n_fails  = 0;
    int half_a = 0, half_b = 0, ph_a = 0, ph_b = 0;
    int base_lat = 0;

    always #2 clk = ~clk;

    freq_ratio_meter #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .WIN_W(WIN_W)) i_freq_ratio_meter (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .window_i(window),
        .loop_a_i(loop_a), .loop_b_i(loop_b),
        .loop_en_a_o(en_a), .loop_en_b_o(en_b), .busy_o(busy),
        .valid_o(valid), .ratio_o(ratio), .div_err_o(err)
    );

    // Loop models: square waves that change away from the sampling edge.
    always @(negedge clk) begin
        if (half_a == 0) loop_a = 1'b0;
        else begin ph_a++; if (ph_a >= half_a) begin ph_a = 0; loop_a = ~loop_a; end end
        if (half_b == 0) loop_b = 1'b0;
        else begin ph_b++; if (ph_b >= half_b) begin ph_b = 0; loop_b = ~loop_b; end end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle(input int ha, input int hb);
        half_a = ha; half_b = hb;
        repeat (12) @(negedge clk);
    endtask

    // One measurement; optional extra start at cycle 'inject' with another window.
    task automatic measure(input int win, input int inject, output int lat,
                           output int na, output int nb, output int both, output int was_valid);
        lat = 0; na = 0; nb = 0; both = 0;
        window = WIN_W'(win);
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        was_valid = int'(valid);
        while (!valid && lat < 20000) begin
            if (en_a) na++;
            if (en_b) nb++;
            if (en_a && en_b) both++;
            if (lat == inject) begin start = 1'b1; window = WIN_W'(7); end
            else start = 1'b0;
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
    endtask

    task automatic test_reset();
        check("R1 en_a", en_a, 0);
        check("R1 en_b", en_b, 0);
        check("R1 busy", busy, 0);
        check("R1 valid", valid, 0);
        check("R1 ratio", ratio, 0);
        check("R1 err", err, 0);
    endtask

    task automatic test_basic();
        int lat, na, nb, both, wv;
        settle(2, 3);
        measure(1200, -1, lat, na, nb, both, wv);
        base_lat = lat;
        check("R2 loop A window", na, 1200);
        check("R2 loop B window", nb, 1200);
        check("R3 exclusive enables", both, 0);
        check("R5 ratio 300/200", ratio, 98304);
        check("R6 no error", err, 0);
    endtask

    task automatic test_restart();
        int lat, na, nb, both, wv;
        settle(3, 2);
        measure(1200, -1, lat, na, nb, both, wv);
        check("R8 valid cleared on restart", wv, 0);
        check("R5 ratio 200/300", ratio, 43690);
        settle(2, 2);
        measure(1200, -1, lat, na, nb, both, wv);
        check("R4 equal loops", ratio, 65536);
    endtask

    task automatic test_ignored_start();
        int lat, na, nb, both, wv;
        settle(2, 3);
        measure(1200, 100, lat, na, nb, both, wv);
        check("R7 latency with start in loop A window", lat, base_lat);
        check("R7 ratio with start in loop A window", ratio, 98304);
        measure(1200, 2405, lat, na, nb, both, wv);
        check("R7 latency with start during divide", lat, base_lat);
        check("R7 loop B window unchanged", nb, 1200);
        repeat (20) @(negedge clk);
        check("R7 valid held", valid, 1);
        check("R7 ratio held", ratio, 98304);
    endtask

    task automatic test_zero_divisor();
        int lat, na, nb, both, wv;
        settle(2, 0);
        measure(400, -1, lat, na, nb, both, wv);
        check("R6 all-ones ratio", ratio, (longint'(1) << RATIO_W) - 1);
        check("R6 error flag", err, 1);
    endtask

    task automatic test_zero_window();
        int lat, na, nb, both, wv;
        settle(2, 2);
        measure(0, -1, lat, na, nb, both, wv);
        check("R9 loop A one cycle", na, 1);
        check("R9 loop B one cycle", nb, 1);
    endtask

    task automatic test_saturation();
        int lat, na, nb, both, wv;
        settle(1, 2);
        measure(4000, -1, lat, na, nb, both, wv);
        check("R10 saturated count A", ratio, 67043);
        check("R10 no error", err, 0);
    endtask

    initial begin
        #(4ns * 200000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        test_reset();
        test_basic();
        test_restart();
        test_ignored_start();
        test_zero_divisor();
        test_zero_window();
        test_saturation();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule